// File: doc/BRIEF.md
# Region-Based Access Protection Checker

This block sits in the path from a bus master port to a memory controller and rules on every access before it reaches memory. Each request carries a 40-bit physical address, a 10-bit master identifier, a direction flag and a secure flag. The request is compared in parallel against sixteen programmable windows. The block returns an allow or deny verdict one clock after the request.

Each window has four registers: a start block, an end block, an identifier match/mask pair and a configuration word. Window bounds have a granularity of 1 MB. The end bound covers its whole final megabyte. When a request falls in no window, a control register supplies separate default permissions for reads and for writes.

Software programs the windows through a plain word-addressed register port. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `regionGuard`

## Requirements
- R1: After reset every register reads back as zero, and every request is denied.
- R2: Register map (byte offsets, word aligned).
  - Control sits at 0x000. Bit 0 is default-read-allowed and bit 1 is default-write-allowed.
  - Window n (0..15) sits at 0x100 + 16·n.
  - At +0 and +4 are the start and end block, held in bits [19:0] and compared with address bits [39:20].
  - At +8 is the identifier register: mask in bits [25:16], ID in bits [9:0].
  - At +12 is the configuration word in bits [3:0].
  - Any bit not listed reads back as zero.
- R3: `verdictValid` is high in exactly the cycle after each cycle with `reqValid` high, and low otherwise. `verdictAllow` is low whenever `verdictValid` is low.
- R4: A request is inside a window when start ≤ address[39:20] ≤ end. With start 0 and end 0x3FF, address 0x0_3FFF_FFFF is inside and 0x0_4000_0000 is outside.
- R5: The identifier matches when (reqId AND mask) equals (ID AND mask). With mask 0xC0 and ID 0x80, any identifier whose bits [7:6] are 10b matches.
- R6: A window takes part only when configuration bit 0 (enable) is set.
- R7: Configuration bit 1 grants reads and bit 2 grants writes.
  - A request that hits at least one window is allowed only if a hit window grants its direction.
  - The defaults are not consulted in that case.
- R8: When configuration bit 3 is clear, only requests with `reqSecure` high can hit the window. When bit 3 is set, non-secure requests hit as well.
- R9: A request that hits no window is allowed for a read when control bit 0 is set, and for a write when control bit 1 is set.
- R10: Overlapping windows combine by OR: a request is allowed if any one hit window grants its direction.
- R11: Writes to offsets outside the map have no effect. This covers misaligned offsets, 0x004–0x0FC and 0x200 and above.
- R12: A register write and a request in the same cycle are judged with the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 40 | Physical address of the request |
| reqId | input | 10 | Master identifier |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSecure | input | 1 | 1 = secure request |
| verdictValid | output | 1 | Verdict present |
| verdictAllow | output | 1 | 1 = allow, 0 = deny |

## Verification
A corrupted bound, mask or configuration bit shows up as a wrong verdict on the first request that touches the affected window. It also shows up at once on a readback of that register. A lost or stray write is equally visible through readback and through later verdicts. A bench model predicts every cycle's verdict, so a divergence is flagged in the cycle it appears rather than at the end of a test. Timing faults in the verdict pipeline show as a valid flag one cycle early or late.

// File: rtl/rgnGuardPkg.sv
`timescale 1ns/1ps
package rgnGuardPkg;
  localparam int IDX_W = 8;

  // configuration word bit positions
  localparam int CFG_EN = 0;
  localparam int CFG_RD = 1;
  localparam int CFG_WR = 2;
  localparam int CFG_NS = 3;

  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_END    = 2'd1,
    FLD_MASTER = 2'd2,
    FLD_CONFIG = 2'd3
  } fieldSel_e;

  typedef struct packed {
    logic             ctrlWe;
    logic             rgnWe;
    logic             ctrlRd;
    logic             rgnRd;
    logic [IDX_W-1:0] rgnIdx;
    fieldSel_e        field;
    logic             evalEn;
  } strobes_t;
endpackage

// File: rtl/guardCtrl.sv
`timescale 1ns/1ps
module guardCtrl
  import rgnGuardPkg::*;
#(
  parameter int NUM_RGN = 16,
  parameter int REG_AW  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              reqValid,
  output strobes_t          stb,
  output logic              verdictValid
);
  localparam logic [REG_AW-9:0] RGN_PAGE = 1;

  logic isCtrl;
  logic idxOk;
  logic inRgn;

  assign isCtrl = (regAddr == '0);

  generate
    if (NUM_RGN >= 16) begin : g_fullIdx
      assign idxOk = 1'b1;
    end else begin : g_partIdx
      assign idxOk = (32'(regAddr[7:4]) < NUM_RGN);
    end
  endgenerate

  assign inRgn = (regAddr[REG_AW-1:8] == RGN_PAGE) && (regAddr[1:0] == 2'b00) && idxOk;

  always_comb begin
    stb.ctrlWe = regWrEn & isCtrl;
    stb.rgnWe  = regWrEn & inRgn;
    stb.ctrlRd = isCtrl;
    stb.rgnRd  = inRgn;
    stb.rgnIdx = IDX_W'(regAddr[7:4]);
    stb.field  = fieldSel_e'(regAddr[3:2]);
    stb.evalEn = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) verdictValid <= 1'b0;
    else       verdictValid <= reqValid;
  end

  // R3
  req_to_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> verdictValid);

  // R3
  verdict_has_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |-> $past(reqValid));

  // R11
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ctrlWe, stb.rgnWe}));
endmodule

// File: rtl/rgnDatapath.sv
`timescale 1ns/1ps
module rgnDatapath
  import rgnGuardPkg::*;
#(
  parameter int NUM_RGN    = 16,
  parameter int ADDR_W     = 40,
  parameter int GRAN_SHIFT = 20,
  parameter int ID_W       = 10,
  parameter int DATA_W     = 32,
  parameter int MASK_POS   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqWrite,
  input  logic              reqSecure,
  output logic              verdictAllow
);
  localparam int BLK_W = ADDR_W - GRAN_SHIFT;
  localparam int RIW   = $clog2(NUM_RGN);
  localparam int CFG_W = 4;

  logic [1:0]       ctrlReg;
  logic [BLK_W-1:0] rgnStart [NUM_RGN];
  logic [BLK_W-1:0] rgnEnd   [NUM_RGN];
  logic [ID_W-1:0]  rgnMask  [NUM_RGN];
  logic [ID_W-1:0]  rgnId    [NUM_RGN];
  logic [CFG_W-1:0] rgnCfg   [NUM_RGN];

  logic [RIW-1:0]   selIdx;
  logic [BLK_W-1:0] reqBlk;
  logic [NUM_RGN-1:0] hitVec;
  logic [NUM_RGN-1:0] grantVec;
  logic [NUM_RGN*CFG_W-1:0] cfgFlat;
  logic allowNext;

  assign selIdx = stb.rgnIdx[RIW-1:0];
  assign reqBlk = reqAddr[ADDR_W-1:GRAN_SHIFT];

  logic unusedBits;
  assign unusedBits = &{1'b0, regWrData, stb.rgnIdx, reqAddr[GRAN_SHIFT-1:0]};

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      for (int n = 0; n < NUM_RGN; n++) begin
        rgnStart[n] <= '0;
        rgnEnd[n]   <= '0;
        rgnMask[n]  <= '0;
        rgnId[n]    <= '0;
        rgnCfg[n]   <= '0;
      end
    end else begin
      if (stb.ctrlWe) ctrlReg <= regWrData[1:0];
      if (stb.rgnWe) begin
        case (stb.field)
          FLD_START:  rgnStart[selIdx] <= regWrData[BLK_W-1:0];
          FLD_END:    rgnEnd[selIdx]   <= regWrData[BLK_W-1:0];
          FLD_MASTER: begin
            rgnMask[selIdx] <= regWrData[MASK_POS +: ID_W];
            rgnId[selIdx]   <= regWrData[ID_W-1:0];
          end
          default:    rgnCfg[selIdx]   <= regWrData[CFG_W-1:0];
        endcase
      end
    end
  end

  // read mux
  always_comb begin
    regRdData = '0;
    if (stb.ctrlRd) begin
      regRdData = DATA_W'(ctrlReg);
    end else if (stb.rgnRd) begin
      case (stb.field)
        FLD_START:  regRdData = DATA_W'(rgnStart[selIdx]);
        FLD_END:    regRdData = DATA_W'(rgnEnd[selIdx]);
        FLD_MASTER: regRdData = (DATA_W'(rgnMask[selIdx]) << MASK_POS) | DATA_W'(rgnId[selIdx]);
        default:    regRdData = DATA_W'(rgnCfg[selIdx]);
      endcase
    end
  end

  // parallel window match
  generate
    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
      logic inRange, idOk, secOk;
      assign inRange = (reqBlk >= rgnStart[g]) && (reqBlk <= rgnEnd[g]);
      assign idOk    = ((reqId ^ rgnId[g]) & rgnMask[g]) == '0;
      assign secOk   = reqSecure | rgnCfg[g][CFG_NS];
      assign hitVec[g]   = rgnCfg[g][CFG_EN] & inRange & idOk & secOk;
      assign grantVec[g] = hitVec[g] & (reqWrite ? rgnCfg[g][CFG_WR] : rgnCfg[g][CFG_RD]);
      assign cfgFlat[g*CFG_W +: CFG_W] = rgnCfg[g];
    end
  endgenerate

  always_comb begin
    if (|hitVec) allowNext = |grantVec;
    else         allowNext = reqWrite ? ctrlReg[1] : ctrlReg[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           verdictAllow <= 1'b0;
    else if (stb.evalEn) verdictAllow <= allowNext;
    else                 verdictAllow <= 1'b0;
  end

  // R3
  idle_no_allow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.evalEn |=> !verdictAllow);

  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ctrlWe |=> $stable(ctrlReg));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rgnWe |=> $stable(cfgFlat));
endmodule

// File: rtl/regionGuard.sv
`timescale 1ns/1ps
module regionGuard
  import rgnGuardPkg::*;
#(
  parameter int NUM_RGN    = 16,
  parameter int ADDR_W     = 40,
  parameter int GRAN_SHIFT = 20,
  parameter int ID_W       = 10,
  parameter int REG_AW     = 12,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqWrite,
  input  logic              reqSecure,
  output logic              verdictValid,
  output logic              verdictAllow
);
  strobes_t stb;

  guardCtrl #(.NUM_RGN(NUM_RGN), .REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .reqValid(reqValid), .stb(stb), .verdictValid(verdictValid)
  );

  rgnDatapath #(.NUM_RGN(NUM_RGN), .ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT),
                .ID_W(ID_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWrData(regWrData), .regRdData(regRdData),
    .reqAddr(reqAddr), .reqId(reqId), .reqWrite(reqWrite), .reqSecure(reqSecure),
    .verdictAllow(verdictAllow)
  );
endmodule

// File: tb/regionGuard_tb.sv
`timescale 1ns/1ps
module regionGuard_tb;
  localparam int NR = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic        regWrEn;
  logic [11:0] regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        reqValid;
  logic [39:0] reqAddr;
  logic [9:0]  reqId;
  logic        reqWrite;
  logic        reqSecure;
  logic        verdictValid;
  logic        verdictAllow;

  regionGuard u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqId(reqId), .reqWrite(reqWrite), .reqSecure(reqSecure),
    .verdictValid(verdictValid), .verdictAllow(verdictAllow)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model state
  logic [19:0] mStart [NR];
  logic [19:0] mEnd   [NR];
  logic [9:0]  mMask  [NR];
  logic [9:0]  mId    [NR];
  logic [3:0]  mCfg   [NR];
  logic [1:0]  mCtrl;

  function automatic void modelReset();
    mCtrl = 2'b00;
    for (int n = 0; n < NR; n++) begin
      mStart[n] = '0; mEnd[n] = '0; mMask[n] = '0; mId[n] = '0; mCfg[n] = '0;
    end
  endfunction

  function automatic logic modelAllow(logic [39:0] a, logic [9:0] id, logic wr, logic sec);
    logic anyHit;
    logic grant;
    anyHit = 1'b0;
    grant  = 1'b0;
    for (int n = 0; n < NR; n++) begin
      if (mCfg[n][0] && a[39:20] >= mStart[n] && a[39:20] <= mEnd[n] &&
          ((id & mMask[n]) == (mId[n] & mMask[n])) && (sec || mCfg[n][3])) begin
        anyHit = 1'b1;
        if (wr ? mCfg[n][2] : mCfg[n][1]) grant = 1'b1;
      end
    end
    if (anyHit) return grant;
    return wr ? mCtrl[1] : mCtrl[0];
  endfunction

  function automatic logic [31:0] modelRead(logic [11:0] a);
    int n;
    if (a == 12'h000) return {30'd0, mCtrl};
    if (a[11:8] != 4'h1 || a[1:0] != 2'b00) return 32'd0;
    n = int'(a[7:4]);
    case (a[3:2])
      2'd0: return {12'd0, mStart[n]};
      2'd1: return {12'd0, mEnd[n]};
      2'd2: return {6'd0, mMask[n], 6'd0, mId[n]};
      default: return {28'd0, mCfg[n]};
    endcase
  endfunction

  function automatic void modelWrite(logic [11:0] a, logic [31:0] d);
    int n;
    if (a == 12'h000) begin
      mCtrl = d[1:0];
    end else if (a[11:8] == 4'h1 && a[1:0] == 2'b00) begin
      n = int'(a[7:4]);
      case (a[3:2])
        2'd0: mStart[n] = d[19:0];
        2'd1: mEnd[n]   = d[19:0];
        2'd2: begin mMask[n] = d[25:16]; mId[n] = d[9:0]; end
        default: mCfg[n] = d[3:0];
      endcase
    end
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs applied now (after a falling edge), outputs checked at next falling edge
  task automatic cycle(input logic doReq, input logic [39:0] a, input logic [9:0] id,
                       input logic wr, input logic sec,
                       input logic doWr, input logic [11:0] wa, input logic [31:0] wd,
                       input string tag);
    logic expV;
    logic expA;
    reqValid  = doReq; reqAddr = a; reqId = id; reqWrite = wr; reqSecure = sec;
    regWrEn   = doWr;  regWrData = wd;
    if (doWr) regAddr = wa;
    expV = doReq;
    expA = doReq ? modelAllow(a, id, wr, sec) : 1'b0;
    if (doWr) modelWrite(wa, wd);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    regWrEn  = 1'b0;
    check(verdictValid == expV && verdictAllow == expA, tag,
          {30'd0, verdictValid, verdictAllow}, {30'd0, expV, expA});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cycle(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, a, d, tag);
  endtask

  task automatic req(input logic [39:0] a, input logic [9:0] id, input logic w, input logic s,
                     input string tag);
    cycle(1'b1, a, id, w, s, 1'b0, '0, '0, tag);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    logic [31:0] e;
    regAddr = a;
    #1;
    e = modelRead(a);
    check(regRdData == e, tag, regRdData, e);
  endtask

  // directed expectation against a literal, then the model-driven cycle
  task automatic reqExp(input logic [39:0] a, input logic [9:0] id, input logic w, input logic s,
                        input logic lit, input string tag);
    check(modelAllow(a, id, w, s) == lit, {tag, " literal"}, {31'd0, modelAllow(a, id, w, s)}, {31'd0, lit});
    req(a, id, w, s, tag);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    reqValid = 1'b0; reqAddr = '0; reqId = '0; reqWrite = 1'b0; reqSecure = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset readback and deny
    rd(12'h000, "R1 ctrl reset");
    for (int n = 0; n < NR; n++) begin
      for (int f = 0; f < 4; f++) rd(12'h100 + 12'(16 * n + 4 * f), "R1 region reset");
    end
    reqExp(40'h0, 10'h0, 1'b0, 1'b1, 1'b0, "R1 read deny");
    reqExp(40'hFF_FFFF_FFFF, 10'h3FF, 1'b1, 1'b0, 1'b0, "R1 write deny");
    cycle(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0, '0, "R3 idle no verdict");

    // control cleared: still deny everything
    wr(12'h000, 32'h0, "R9 ctrl clear");
    reqExp(40'h12_3456_7890, 10'h80, 1'b0, 1'b1, 1'b0, "R9 no default read");

    // window 0: first 1 GB, APU-like ID match, secure rd/wr
    wr(12'h10C, 32'h7, "R2 cfg0");
    wr(12'h100, 32'h0, "R2 start0");
    wr(12'h104, 32'hFFFF_F3FF, "R2 end0");
    wr(12'h108, 32'h00C0_0080, "R2 master0");
    rd(12'h104, "R2 end unused bits");
    check(regRdData == 32'h000F_F3FF, "R2 end literal", regRdData, 32'h000F_F3FF);
    wr(12'h104, 32'h3FF, "R2 end0 again");
    rd(12'h108, "R2 master readback");
    check(regRdData == 32'h00C0_0080, "R2 master literal", regRdData, 32'h00C0_0080);
    rd(12'h10C, "R2 cfg readback");

    reqExp(40'h0_3FFF_FFFF, 10'h080, 1'b0, 1'b1, 1'b1, "R4 inclusive end read");
    reqExp(40'h0_4000_0000, 10'h080, 1'b0, 1'b1, 1'b0, "R4 past end");
    reqExp(40'h0_0000_0000, 10'h080, 1'b1, 1'b1, 1'b1, "R4 start write");
    reqExp(40'h0_2000_0000, 10'h0BF, 1'b0, 1'b1, 1'b1, "R5 low bits ignored");
    reqExp(40'h0_2000_0000, 10'h280, 1'b0, 1'b1, 1'b1, "R5 high bits ignored");
    reqExp(40'h0_2000_0000, 10'h0C0, 1'b0, 1'b1, 1'b0, "R5 mismatch 11");
    reqExp(40'h0_2000_0000, 10'h040, 1'b0, 1'b1, 1'b0, "R5 mismatch 01");
    reqExp(40'h0_2000_0000, 10'h080, 1'b0, 1'b0, 1'b0, "R8 nonsecure blocked");
    wr(12'h10C, 32'hF, "R8 cfg ns");
    reqExp(40'h0_2000_0000, 10'h080, 1'b0, 1'b0, 1'b1, "R8 nonsecure allowed");

    // R7: read-only window, defaults permissive for writes
    wr(12'h10C, 32'h3, "R7 cfg ro");
    wr(12'h000, 32'hFFFF_FFFE, "R9 ctrl default write");
    rd(12'h000, "R2 ctrl readback");
    reqExp(40'h0_1000_0000, 10'h080, 1'b1, 1'b1, 1'b0, "R7 hit overrides default");
    reqExp(40'h0_1000_0000, 10'h080, 1'b0, 1'b1, 1'b1, "R7 read granted");
    reqExp(40'h1_0000_0000, 10'h080, 1'b1, 1'b1, 1'b1, "R9 default write");
    reqExp(40'h1_0000_0000, 10'h080, 1'b0, 1'b1, 1'b0, "R9 default read off");

    // R6: disabled window falls back to defaults
    wr(12'h10C, 32'h6, "R6 cfg disabled");
    reqExp(40'h0_1000_0000, 10'h080, 1'b1, 1'b1, 1'b1, "R6 disabled uses default wr");
    reqExp(40'h0_1000_0000, 10'h080, 1'b0, 1'b1, 1'b0, "R6 disabled uses default rd");

    // R10: overlap, window 0 read-only, window 15 write-only any ID
    wr(12'h000, 32'h0, "R10 ctrl clear");
    wr(12'h10C, 32'h3, "R10 cfg0");
    wr(12'h1F0, 32'h3FF, "R10 start15");
    wr(12'h1F4, 32'h3FF, "R10 end15");
    wr(12'h1F8, 32'h0, "R10 master15");
    wr(12'h1FC, 32'h5, "R10 cfg15");
    reqExp(40'h0_3FF0_0000, 10'h080, 1'b1, 1'b1, 1'b1, "R10 write via window 15");
    reqExp(40'h0_3FF0_0000, 10'h080, 1'b0, 1'b1, 1'b1, "R10 read via window 0");
    reqExp(40'h0_3FE0_0000, 10'h080, 1'b1, 1'b1, 1'b0, "R10 write outside 15");

    // R11: unmapped writes ignored
    wr(12'h004, 32'hFFFF_FFFF, "R11 gap");
    wr(12'h0FC, 32'hFFFF_FFFF, "R11 gap top");
    wr(12'h200, 32'hFFFF_FFFF, "R11 above");
    wr(12'h10D, 32'hFFFF_FFFF, "R11 misaligned");
    rd(12'h000, "R11 ctrl intact");
    check(regRdData == 32'h0, "R11 ctrl literal", regRdData, 32'h0);
    rd(12'h10C, "R11 cfg0 intact");
    check(regRdData == 32'h3, "R11 cfg0 literal", regRdData, 32'h3);
    rd(12'h004, "R2 gap reads zero");
    reqExp(40'h5_0000_0000, 10'h080, 1'b0, 1'b1, 1'b0, "R11 still deny");

    // R12: same-cycle write and request uses old contents
    cycle(1'b1, 40'h0_0010_0000, 10'h080, 1'b0, 1'b1, 1'b1, 12'h10C, 32'h0, "R12 old cfg used");
    reqExp(40'h0_0010_0000, 10'h080, 1'b0, 1'b1, 1'b0, "R12 new cfg used");

    // random mix checked against the model each clock
    for (int i = 0; i < 1500; i++) begin
      logic [11:0] wa;
      logic [31:0] wd;
      logic [39:0] ra;
      wa = ($urandom_range(0, 9) == 0) ? 12'($urandom) : 12'h100 + 12'($urandom_range(0, 63) * 4);
      if ($urandom_range(0, 7) == 0) wa = 12'h000;
      case (wa[3:2])
        2'd0, 2'd1: wd = 32'($urandom_range(0, 24));
        default:    wd = $urandom;
      endcase
      ra = {20'($urandom_range(0, 26)), 20'($urandom)};
      cycle(1'($urandom), ra, 10'($urandom), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 2) == 0), wa, wd, "R10 random mix");
      if (i % 50 == 0) rd(12'h100 + 12'($urandom_range(0, 63) * 4), "R2 random readback");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule